// File: doc/BRIEF.md
# Ultra DMA Word-Parallel CRC-16 Checker

This block keeps the running 16-bit CRC over the data words of an Ultra DMA burst. The burst may run in either direction. An upstream strobe synchroniser hands over one 16-bit word per `word_valid` pulse. The block folds the whole word into the CRC register in a single clock. A bit clock would be too slow, so the update uses a flat XOR network derived from the generator polynomial x^16 + x^12 + x^5 + 1 (0x1021).

At the start of every burst the register is reloaded with 0x4ABA. At the end of a burst, control logic presents the CRC word received from the other side on `crc_rx` together with a `crc_check` pulse. The block compares that word with its running value. A difference raises a sticky interface-CRC error flag, which feeds the error-reporting bit of the Error register at command completion. The flag survives the later bursts of a multi-burst command and is cleared when the next command is written.

Top module: `udma_crc16_check`

## Requirements
- R1: While `rst` is high at a clock edge, `crc_value` becomes 0x4ABA and `crc_err` becomes 0 after that edge.
- R2: A `burst_start` pulse loads 0x4ABA into `crc_value` after the edge. This takes priority over a `word_valid` in the same cycle, whose word is dropped.
- R3: Each `word_valid` without `burst_start` updates `crc_value` after the edge to the result of shifting all 16 bits of `word_data` through the polynomial 0x1021. Bit 0 is shifted first, and for each bit the feedback is the register's bit 15 XOR the data bit.
- R4: In a cycle with neither `word_valid` nor `burst_start`, `crc_value` keeps its value.
- R5: A `crc_check` whose `crc_rx` equals the current `crc_value` leaves `crc_err` unchanged.
- R6: A `crc_check` whose `crc_rx` differs from the current `crc_value` sets `crc_err` to 1 after the edge.
- R7: Once set, `crc_err` stays at 1 across later bursts and matching checks until `cmd_start`.
- R8: `cmd_start` clears `crc_err` after the edge. A mismatching `crc_check` in the same cycle wins and leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| burst_start | input | 1 | Pulse when the burst acknowledge is asserted; reseeds the CRC |
| word_valid | input | 1 | One data word is present on `word_data` |
| word_data | input | 16 | Data word captured from either strobe edge |
| crc_check | input | 1 | End of burst; compare `crc_rx` with the running CRC |
| crc_rx | input | 16 | CRC word sent by the other side |
| cmd_start | input | 1 | New command written; clears the error flag |
| crc_value | output | 16 | Registered running CRC |
| crc_err | output | 1 | Sticky interface-CRC error flag |

## Verification
The bench builds the block with its default 16-bit word and 16-bit CRC widths and the standard seed. At these values every result can be compared against a bit-serial reference shift written in the bench. Bursts of different lengths, a 200-word pseudo-random stream and single-bit corruptions of the peer CRC word are covered. Directed cases cover reseeding while a word arrives, idle holding, sticky behaviour over several bursts, and the clear colliding with a fresh mismatch.

// File: rtl/udma_crc_pkg.sv
package udma_crc_pkg;
  localparam int unsigned CRC_W  = 16;
  localparam int unsigned WORD_W = 16;
  localparam logic [CRC_W-1:0] CRC_POLY = 16'h1021;
  localparam logic [CRC_W-1:0] CRC_SEED = 16'h4ABA;

  // One word folded bit-serially, bit 0 first; used only to derive masks.
  function automatic logic [CRC_W-1:0] fold_serial(
      input logic [CRC_W-1:0] c, input logic [WORD_W-1:0] d);
    logic [CRC_W-1:0] r;
    logic fb;
    r = c;
    for (int i = 0; i < WORD_W; i++) begin
      fb = r[CRC_W-1] ^ d[i];
      r  = {r[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
    end
    return r;
  endfunction

  // Mask of {data, crc} bits that feed next-state bit j (linear map).
  function automatic logic [CRC_W+WORD_W-1:0] fold_mask(input int j);
    logic [CRC_W+WORD_W-1:0] m;
    logic [CRC_W-1:0] v;
    m = '0;
    for (int k = 0; k < CRC_W + WORD_W; k++) begin
      if (k < CRC_W) v = fold_serial(CRC_W'(1) << k, '0);
      else           v = fold_serial('0, WORD_W'(1) << (k - CRC_W));
      m[k] = v[j];
    end
    return m;
  endfunction
endpackage

// File: rtl/udma_crc_xor_net.sv
module udma_crc_xor_net
  import udma_crc_pkg::*;
(
  input  logic [CRC_W-1:0]  crc_in,
  input  logic [WORD_W-1:0] data_in,
  output logic [CRC_W-1:0]  crc_out
);
  localparam int unsigned IN_W = CRC_W + WORD_W;
  logic [IN_W-1:0] flat;
  assign flat = {data_in, crc_in};

  for (genvar j = 0; j < CRC_W; j++) begin : g_bit
    localparam logic [IN_W-1:0] MASK = fold_mask(j);
    assign crc_out[j] = ^(flat & MASK);
  end
endmodule

// File: rtl/udma_crc_reg.sv
module udma_crc_reg
  import udma_crc_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             reseed,
  input  logic             advance,
  input  logic [CRC_W-1:0] crc_next,
  output logic [CRC_W-1:0] crc_q
);
  always_ff @(posedge clk) begin
    if (rst || reseed) crc_q <= CRC_SEED;
    else if (advance)  crc_q <= crc_next;
  end
endmodule

// File: rtl/udma_crc_compare.sv
module udma_crc_compare
  import udma_crc_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             check,
  input  logic [CRC_W-1:0] peer_crc,
  input  logic [CRC_W-1:0] local_crc,
  input  logic             clear,
  output logic             err_q
);
  logic miss;
  assign miss = check && (peer_crc != local_crc);

  always_ff @(posedge clk) begin
    if (rst)        err_q <= 1'b0;
    else if (miss)  err_q <= 1'b1;
    else if (clear) err_q <= 1'b0;
  end
endmodule

// File: rtl/udma_crc16_check.sv
module udma_crc16_check
  import udma_crc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              burst_start,
  input  logic              word_valid,
  input  logic [WORD_W-1:0] word_data,
  input  logic              crc_check,
  input  logic [CRC_W-1:0]  crc_rx,
  input  logic              cmd_start,
  output logic [CRC_W-1:0]  crc_value,
  output logic              crc_err
);
  logic [CRC_W-1:0] crc_q;
  logic [CRC_W-1:0] crc_nx;

  udma_crc_xor_net u_net (
    .crc_in (crc_q),
    .data_in(word_data),
    .crc_out(crc_nx)
  );

  udma_crc_reg u_reg (
    .clk     (clk),
    .rst     (rst),
    .reseed  (burst_start),
    .advance (word_valid),
    .crc_next(crc_nx),
    .crc_q   (crc_q)
  );

  udma_crc_compare u_cmp (
    .clk      (clk),
    .rst      (rst),
    .check    (crc_check),
    .peer_crc (crc_rx),
    .local_crc(crc_q),
    .clear    (cmd_start),
    .err_q    (crc_err)
  );

  assign crc_value = crc_q;
endmodule

// File: rtl/udma_crc16_check_sva.sv
module udma_crc16_check_sva
  import udma_crc_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              burst_start,
  input logic              word_valid,
  input logic [WORD_W-1:0] word_data,
  input logic              crc_check,
  input logic [CRC_W-1:0]  crc_rx,
  input logic              cmd_start,
  input logic [CRC_W-1:0]  crc_value,
  input logic              crc_err
);
  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (crc_value == CRC_SEED) && !crc_err);

  assert_reseed_R2: assert property (@(posedge clk) disable iff (rst)
    burst_start |=> crc_value == CRC_SEED);

  assert_idle_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (!burst_start && !word_valid) |=> $stable(crc_value));

  assert_match_keeps_R5: assert property (@(posedge clk) disable iff (rst)
    (crc_check && crc_rx == crc_value && !crc_err && !cmd_start) |=> !crc_err);

  assert_miss_sets_R6: assert property (@(posedge clk) disable iff (rst)
    (crc_check && crc_rx != crc_value) |=> crc_err);

  assert_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    (crc_err && !cmd_start) |=> crc_err);

  assert_clear_R8: assert property (@(posedge clk) disable iff (rst)
    (cmd_start && !(crc_check && crc_rx != crc_value)) |=> !crc_err);
endmodule

bind udma_crc16_check udma_crc16_check_sva u_sva (.*);

// File: tb/sim_udma_crc16_check.sv
module sim_udma_crc16_check;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        burst_start = 1'b0;
  logic        word_valid = 1'b0;
  logic [15:0] word_data = '0;
  logic        crc_check = 1'b0;
  logic [15:0] crc_rx = '0;
  logic        cmd_start = 1'b0;
  logic [15:0] crc_value;
  logic        crc_err;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  logic [15:0] ref_crc;
  logic        ref_err;
  logic [15:0] rng;

  always #5 clk = ~clk;

  udma_crc16_check u0 (.*);

  // Vector: {words[7:0], stream seed[15:0], peer corruption[15:0], new cmd[0]}
  localparam logic [40:0] VEC [8] = '{
    {8'd1,  16'h0000, 16'h0000, 1'b1},
    {8'd4,  16'hA5A5, 16'h0000, 1'b0},
    {8'd3,  16'h1234, 16'h0001, 1'b0},
    {8'd6,  16'hFFFF, 16'h0000, 1'b0},
    {8'd2,  16'h8001, 16'h0000, 1'b1},
    {8'd9,  16'h0F0F, 16'h8000, 1'b0},
    {8'd5,  16'h7E57, 16'h0000, 1'b1},
    {8'd16, 16'hC3C3, 16'h0000, 1'b0}
  };

  function automatic logic [15:0] ref_fold(input logic [15:0] c, input logic [15:0] d);
    logic [15:0] r = c;
    for (int i = 0; i < 16; i++) begin
      if (r[15] ^ d[i]) r = {r[14:0], 1'b0} ^ 16'h1021;
      else              r = {r[14:0], 1'b0};
    end
    return r;
  endfunction

  function automatic logic [15:0] next_rng(input logic [15:0] x);
    logic [15:0] y = (x == 0) ? 16'h1D2B : x;
    y ^= y << 7; y ^= y >> 9; y ^= y << 8;
    return y;
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send_word(input logic [15:0] w);
    @(negedge clk); word_valid = 1'b1; word_data = w;
    @(negedge clk); word_valid = 1'b0;
    ref_crc = ref_fold(ref_crc, w);
  endtask

  task automatic start_burst();
    @(negedge clk); burst_start = 1'b1;
    @(negedge clk); burst_start = 1'b0;
    ref_crc = 16'h4ABA;
  endtask

  task automatic check_peer(input logic [15:0] corrupt);
    @(negedge clk); crc_check = 1'b1; crc_rx = ref_crc ^ corrupt;
    @(negedge clk); crc_check = 1'b0;
    if (corrupt != 0) ref_err = 1'b1;
  endtask

  task automatic new_cmd();
    @(negedge clk); cmd_start = 1'b1;
    @(negedge clk); cmd_start = 1'b0;
    ref_err = 1'b0;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      fails++; checks++;
      $display("FAIL R3 watchdog actual=%0d expected=<150000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    ref_crc = 16'h4ABA; ref_err = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R1 reset crc", crc_value, 16'h4ABA);
    chk("R1 reset err", {15'd0, crc_err}, 16'd0);

    // table-driven bursts
    for (int v = 0; v < 8; v++) begin
      if (VEC[v][0]) new_cmd();
      start_burst();
      chk("R2 reseed", crc_value, ref_crc);
      rng = VEC[v][32:17];
      for (int n = 0; n < int'(VEC[v][40:33]); n++) begin
        rng = next_rng(rng);
        send_word(rng);
        chk("R3 word fold", crc_value, ref_crc);
      end
      check_peer(VEC[v][16:1]);
      if (VEC[v][16:1] != 0) chk("R6 mismatch flag", {15'd0, crc_err}, {15'd0, ref_err});
      else chk("R5 R7 match keeps flag", {15'd0, crc_err}, {15'd0, ref_err});
    end

    // R4: idle cycles hold the value
    new_cmd(); start_burst(); send_word(16'hBEEF);
    repeat (5) @(negedge clk);
    chk("R4 idle hold", crc_value, ref_crc);

    // R2: reseed wins over a simultaneous word
    @(negedge clk); burst_start = 1'b1; word_valid = 1'b1; word_data = 16'h5555;
    @(negedge clk); burst_start = 1'b0; word_valid = 1'b0;
    ref_crc = 16'h4ABA;
    chk("R2 reseed priority", crc_value, 16'h4ABA);

    // R3: long pseudo-random stream
    rng = 16'h3C91;
    for (int n = 0; n < 200; n++) begin
      rng = next_rng(rng);
      send_word(rng);
    end
    chk("R3 long stream", crc_value, ref_crc);
    check_peer(16'h0000);
    chk("R5 long stream match", {15'd0, crc_err}, 16'd0);

    // R7: sticky across a second matching burst
    start_burst(); send_word(16'h0001); check_peer(16'h0400);
    start_burst(); send_word(16'h1111); send_word(16'h2222); check_peer(16'h0000);
    chk("R7 sticky", {15'd0, crc_err}, 16'd1);

    // R8: clear, then clear colliding with mismatch
    new_cmd();
    chk("R8 clear", {15'd0, crc_err}, 16'd0);
    start_burst(); send_word(16'h00FF);
    @(negedge clk); cmd_start = 1'b1; crc_check = 1'b1; crc_rx = ref_crc ^ 16'h0002;
    @(negedge clk); cmd_start = 1'b0; crc_check = 1'b0;
    chk("R8 set wins", {15'd0, crc_err}, 16'd1);

    // R1: reset mid-run
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk("R1 reset crc again", crc_value, 16'h4ABA);
    chk("R1 reset err again", {15'd0, crc_err}, 16'd0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule